// File: doc/BRIEF.md
# SPI Slot Register File

This block is a serial register file reached over a four-wire SPI link in mode 0. An external controller opens a frame by pulling the active-low select low. It clocks one header byte and then up to eight payload bytes, most significant bit first. The block holds sixty-four 64-bit channel slots and a few control registers: a 2-bit bank number, two 4-bit indicator nibbles and a live view of four switch inputs. Downstream timing logic, which is outside this block, reads any slot through a combinational consumer port.

The upper two bits of the header choose the operation and the lower six bits give a slot number or a command code. A slot write is full duplex: while the eight new payload bytes arrive, the old slot contents leave on MISO. The new value is stored only when select is released after all 64 payload bits have arrived. A slot read returns the stored value and ignores MOSI. Command frames answer inside the header byte itself, in its last four bit times. A write returns the value the register held before the write.

All pin inputs pass through two-flop synchronisers into the system clock domain, and SCK edges are detected there. Each half-period of SCK must therefore last at least six system clock cycles.

Top module: `spi_slot_regfile`

## Requirements
- R1: After reset, every slot holds 64'h00002000_00002000 (in each 32-bit half: note 0, level 0, bend 0x2000). The bank is 0, both indicator nibbles are 0 and MISO is 0.
- R2: A frame lasts while `spi_cs_n` is low. The block samples MOSI on rising SCK, changes MISO after falling SCK and sends MSB first. Each SCK half-period must be at least 6 system clocks long.
- R3: Bits [7:6] of the header select the operation: 2'b00 slot write, 2'b10 slot read, 2'b01 command write, 2'b11 command read. Bits [5:0] carry the slot number or the command code.
- R4: In a slot write, the 64 payload bits (the first payload byte is bits 63:56) replace the slot when select rises, provided all 64 bits arrived.
- R5: During the payload of a slot write, MISO returns the slot's previous contents, MSB first.
- R6: A slot read returns the slot value MSB first during the 64 payload bits, ignores MOSI and leaves the slot unchanged.
- R7: A slot write whose frame ends before 64 payload bits arrive leaves the slot unchanged.
- R8: In a command frame, header output bits [7:4] are 0 and bits [3:0] carry the response. The response source is picked by code[5:4]: 00 bank, 01 switches, 10 low nibble, 11 high nibble. A write answers with the value before the write. MISO is 0 whenever no frame is open.
- R9: Command-write code 6'b0001bb sets the bank to bb and answers with the previous bank.
- R10: Command-write codes 6'b10dddd and 6'b11dddd set the low or high indicator nibble to dddd. Command-read codes 6'b100000 and 6'b110000 return the current low or high nibble.
- R11: Command-read code 6'b010000 returns the present value of `sw_in`.
- R12: Command-write code 6'b000000 restores every slot to the R1 default. The bank and the indicator nibbles keep their values.
- R13: `cons_data` always shows the stored contents of slot `cons_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| sw_in | input | 4 | Switch inputs reported by the switch command |
| cons_addr | input | 6 | Slot number for the consumer port |
| cons_data | output | 64 | Contents of the slot chosen by `cons_addr` |
| bank_sel | output | 2 | Current bank number |
| ind_lo | output | 4 | Low indicator nibble |
| ind_hi | output | 4 | High indicator nibble |

## Verification
After a falling SCK, the next MISO bit is due within four system clocks: three for synchronisation and edge detection, one for the output register. The bench waits six clocks after each falling edge and samples on the negative clock edge just before it raises SCK. A slot write commits three clocks after select rises, and a command takes effect about three clocks after the eighth rising SCK. The bench therefore reads `cons_data`, `bank_sel` and the indicator outputs only six clocks after select has been released, well beyond those delays. Full sweeps of all slots, banks, nibble values and switch patterns compare against values the bench computes itself.

// File: rtl/slotreg_pkg.sv
package slotreg_pkg;
    localparam int SLOT_W    = 64;
    localparam int NUM_SLOTS = 64;
    localparam int ADDR_W    = 6;
    localparam int HDR_BITS  = 8;
    localparam int NIB_W     = 4;
    localparam logic [31:0] HALF_DEFAULT = 32'h0000_2000;
    localparam logic [63:0] SLOT_DEFAULT = {HALF_DEFAULT, HALF_DEFAULT};

    typedef enum logic [1:0] {
        OP_SLOT_WR = 2'b00,
        OP_CMD_WR  = 2'b01,
        OP_SLOT_RD = 2'b10,
        OP_CMD_RD  = 2'b11
    } op_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_start,
    output logic sel_end,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] dat;
        logic              sck_prev;
        logic              cs_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.sck      = {q.sck[TOP-1:0], sck};
        d.cs       = {q.cs[TOP-1:0], cs_n};
        d.dat      = {q.dat[TOP-1:0], mosi};
        d.sck_prev = q.sck[TOP];
        d.cs_prev  = q.cs[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck      <= '0;
            q.cs       <= '1;
            q.dat      <= '0;
            q.sck_prev <= 1'b0;
            q.cs_prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_rise  =  q.sck[TOP] & ~q.sck_prev;
    assign sck_fall  = ~q.sck[TOP] &  q.sck_prev;
    assign sel_start = ~q.cs[TOP]  &  q.cs_prev;
    assign sel_end   =  q.cs[TOP]  & ~q.cs_prev;
    assign mosi_s    =  q.dat[TOP];
endmodule

// File: rtl/slot_store.sv
module slot_store #(
    parameter int          NUM     = 64,
    parameter int          W       = 64,
    parameter logic [63:0] RST_VAL = 64'h0000_2000_0000_2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     we,
    input  logic [$clog2(NUM)-1:0]   waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(NUM)-1:0]   raddr_a,
    output logic [W-1:0]             rdata_a,
    input  logic [$clog2(NUM)-1:0]   raddr_b,
    output logic [W-1:0]             rdata_b
);
    localparam int AW = $clog2(NUM);
    localparam logic [W-1:0] INIT = W'(RST_VAL);

    logic [NUM-1:0][W-1:0] slots_flat;

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        logic [W-1:0] slot_d, slot_q;
        always_comb begin
            slot_d = slot_q;
            if (clear)
                slot_d = INIT;
            else if (we && waddr == AW'(g))
                slot_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= INIT;
            else        slot_q <= slot_d;
        end
        assign slots_flat[g] = slot_q;
    end

    assign rdata_a = slots_flat[raddr_a];
    assign rdata_b = slots_flat[raddr_b];

    assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clear) |=> slots_flat[$past(waddr)] == $past(wdata));

    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (slots_flat[0] == INIT && slots_flat[NUM-1] == INIT));

    // R6 and R7: with neither write nor clear, the slot on port b holds its value
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clear) |=> slots_flat[$past(raddr_b)] == $past(rdata_b));
endmodule

// File: rtl/spi_slot_engine.sv
module spi_slot_engine
    import slotreg_pkg::*;
#(
    parameter int SLOT_W_P   = SLOT_W,
    parameter int HDR_BITS_P = HDR_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  sel_start,
    input  logic                  sel_end,
    input  logic                  mosi_s,
    input  logic [NIB_W-1:0]      sw_in,
    input  logic [SLOT_W_P-1:0]   rd_data,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  we,
    output logic [ADDR_W-1:0]     waddr,
    output logic [SLOT_W_P-1:0]   wdata,
    output logic                  clear,
    output logic                  miso,
    output logic [1:0]            bank,
    output logic [NIB_W-1:0]      ind_lo,
    output logic [NIB_W-1:0]      ind_hi
);
    localparam int FRAME_BITS = HDR_BITS_P + SLOT_W_P;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] C_HDR   = CNT_W'(HDR_BITS_P);
    localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] C_RESP  = CNT_W'(HDR_BITS_P - NIB_W);

    typedef struct packed {
        logic                  active;
        logic [CNT_W-1:0]      cnt;
        logic [7:0]            hdr;
        logic [SLOT_W_P-1:0]   rx;
        logic [SLOT_W_P-1:0]   tx;
        logic [NIB_W-1:0]      resp;
        logic                  miso;
        logic [1:0]            bank;
        logic [NIB_W-1:0]      lo;
        logic [NIB_W-1:0]      hi;
    } eng_t;

    eng_t q, d;
    logic [7:0]       hdr_full;
    logic [NIB_W-1:0] resp_sel;

    always_comb begin
        d        = q;
        we       = 1'b0;
        clear    = 1'b0;
        hdr_full = {q.hdr[6:0], mosi_s};
        // q.hdr[1:0] holds code[5:4] once four header bits are in
        case (q.hdr[1:0])
            2'b00:   resp_sel = {2'b00, q.bank};
            2'b01:   resp_sel = sw_in;
            2'b10:   resp_sel = q.lo;
            default: resp_sel = q.hi;
        endcase

        if (sel_start) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.hdr    = '0;
            d.miso   = 1'b0;
        end else if (q.active) begin
            if (sck_rise) begin
                if (q.cnt < C_HDR)
                    d.hdr = hdr_full;
                else if (q.cnt < C_FRAME)
                    d.rx = {q.rx[SLOT_W_P-2:0], mosi_s};
                if (q.cnt < C_FRAME)
                    d.cnt = q.cnt + 1'b1;
                if (q.cnt == C_HDR - 1'b1 && hdr_full[7:6] == OP_CMD_WR) begin
                    case (hdr_full[5:4])
                        2'b00: begin
                            if (hdr_full[3:0] == 4'h0)
                                clear = 1'b1;
                            else if (hdr_full[3:2] == 2'b01)
                                d.bank = hdr_full[1:0];
                        end
                        2'b10:   d.lo = hdr_full[3:0];
                        2'b11:   d.hi = hdr_full[3:0];
                        default: ;
                    endcase
                end
            end else if (sck_fall) begin
                if (q.cnt == C_RESP) begin
                    if (q.hdr[2]) begin
                        d.miso = resp_sel[NIB_W-1];
                        d.resp = {resp_sel[NIB_W-2:0], 1'b0};
                    end else begin
                        d.miso = 1'b0;
                        d.resp = '0;
                    end
                end else if (q.cnt > C_RESP && q.cnt < C_HDR) begin
                    d.miso = q.resp[NIB_W-1];
                    d.resp = {q.resp[NIB_W-2:0], 1'b0};
                end else if (q.cnt == C_HDR) begin
                    if (!q.hdr[6]) begin
                        d.miso = rd_data[SLOT_W_P-1];
                        d.tx   = {rd_data[SLOT_W_P-2:0], 1'b0};
                    end else begin
                        d.miso = 1'b0;
                        d.tx   = '0;
                    end
                end else if (q.cnt > C_HDR && q.cnt < C_FRAME) begin
                    d.miso = q.tx[SLOT_W_P-1];
                    d.tx   = {q.tx[SLOT_W_P-2:0], 1'b0};
                end else begin
                    d.miso = 1'b0;
                end
            end
            if (sel_end) begin
                d.active = 1'b0;
                d.miso   = 1'b0;
                if (q.hdr[7:6] == OP_SLOT_WR && q.cnt == C_FRAME)
                    we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr = q.hdr[ADDR_W-1:0];
    assign waddr   = q.hdr[ADDR_W-1:0];
    assign wdata   = q.rx;
    assign miso    = q.miso;
    assign bank    = q.bank;
    assign ind_lo  = q.lo;
    assign ind_hi  = q.hi;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= C_FRAME);

    assert_miso_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_end |=> !miso);

    // R9 and R10: control registers move only on a sampled rising SCK
    assert_ctrl_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable({bank, ind_lo, ind_hi}));

    assert_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $past(q.cnt) == C_FRAME);
endmodule

// File: rtl/spi_slot_regfile.sv
module spi_slot_regfile
    import slotreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [NIB_W-1:0]  sw_in,
    input  logic [ADDR_W-1:0] cons_addr,
    output logic [SLOT_W-1:0] cons_data,
    output logic [1:0]        bank_sel,
    output logic [NIB_W-1:0]  ind_lo,
    output logic [NIB_W-1:0]  ind_hi
);
    logic sck_rise, sck_fall, sel_start, sel_end, mosi_s;
    logic we, clear;
    logic [ADDR_W-1:0] waddr, rd_addr;
    logic [SLOT_W-1:0] wdata, rd_data;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sel_start(sel_start), .sel_end(sel_end), .mosi_s(mosi_s)
    );

    spi_slot_engine i_engine (
        .clk(clk), .rst_n(rst_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sel_start(sel_start), .sel_end(sel_end), .mosi_s(mosi_s),
        .sw_in(sw_in), .rd_data(rd_data), .rd_addr(rd_addr),
        .we(we), .waddr(waddr), .wdata(wdata), .clear(clear),
        .miso(spi_miso), .bank(bank_sel), .ind_lo(ind_lo), .ind_hi(ind_hi)
    );

    slot_store #(.NUM(NUM_SLOTS), .W(SLOT_W), .RST_VAL(SLOT_DEFAULT)) i_store (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .we(we), .waddr(waddr), .wdata(wdata),
        .raddr_a(rd_addr), .rdata_a(rd_data),
        .raddr_b(cons_addr), .rdata_b(cons_data)
    );
endmodule

// File: tb/test_spi_slot_regfile.sv
module test_spi_slot_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam logic [63:0] DEF = 64'h0000_2000_0000_2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [3:0]  sw = 4'h0;
    logic [5:0]  caddr = 6'd0;
    logic [63:0] cdata;
    logic [1:0]  bank;
    logic [3:0]  lo, hi;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_slot_regfile i_spi_slot_regfile (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .sw_in(sw), .cons_addr(caddr), .cons_data(cdata),
        .bank_sel(bank), .ind_lo(lo), .ind_hi(hi)
    );

    function automatic logic [63:0] pat(int i, int s);
        return {8'(i + s), 8'(~i), 16'(i * 97 + s * 13), 32'((i * 32'h0101_0101) ^ (s * 32'h5A5A_0F0F))};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R2: mode 0, MSB first; MISO sampled just before each rising SCK
    task automatic xfer(input logic [7:0] hdr, input logic [63:0] txd, input int ndata,
                        output logic [7:0] r0, output logic [63:0] rx);
        r0 = '0; rx = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < 8 + ndata; b++) begin
            mosi = (b < 8) ? hdr[7-b] : txd[63-(b-8)];
            repeat (HALF) @(negedge clk);
            if (b < 8) r0[7-b] = miso; else rx[63-(b-8)] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        mosi = 1'b0; cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic slot_at(int i, logic [63:0] exp, string req);
        caddr = 6'(i);
        #1;
        check(req, cdata, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  r0;
        logic [63:0] rx;
        logic [1:0]  pb;
        logic [3:0]  pn;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1 miso", 64'(miso), 64'd0);
        check("R1 bank", 64'(bank), 64'd0);
        check("R1 nibbles", 64'({hi, lo}), 64'd0);
        for (int i = 0; i < 64; i++) slot_at(i, DEF, "R1 R13 slot default");

        // R3 R4 R5: full-duplex write of every slot
        for (int i = 0; i < 64; i++) begin
            xfer({2'b00, 6'(i)}, pat(i, 1), 64, r0, rx);
            check("R5 readback", rx, DEF);
            slot_at(i, pat(i, 1), "R4 R3 commit");
            check("R8 idle miso", 64'(miso), 64'd0);
        end

        // R6: read with MOSI held high
        for (int i = 0; i < 64; i += 8) begin
            xfer({2'b10, 6'(i)}, '1, 64, r0, rx);
            check("R6 read value", rx, pat(i, 1));
            slot_at(i, pat(i, 1), "R6 unchanged");
        end

        // R5: second write returns the first pattern
        for (int i = 0; i < 64; i += 4) begin
            xfer({2'b00, 6'(i)}, pat(i, 2), 64, r0, rx);
            check("R5 old value", rx, pat(i, 1));
            slot_at(i, pat(i, 2), "R4 rewrite");
        end

        // R7: short frames leave slot alone
        xfer({2'b00, 6'd5}, pat(5, 3), 32, r0, rx);
        slot_at(5, pat(5, 1), "R7 32-bit abort");
        xfer({2'b00, 6'd5}, pat(5, 3), 63, r0, rx);
        slot_at(5, pat(5, 1), "R7 63-bit abort");
        xfer({2'b00, 6'd5}, pat(5, 3), 0, r0, rx);
        slot_at(5, pat(5, 1), "R7 header only");

        // R9: bank sweep
        pb = 2'd0;
        for (int k = 0; k < 4; k++) begin
            logic [1:0] nb;
            nb = 2'(k + 2);
            xfer({2'b01, 4'b0001, nb}, '0, 0, r0, rx);
            check("R9 R8 prior bank", 64'(r0), 64'({2'b00, pb}));
            check("R9 bank out", 64'(bank), 64'(nb));
            pb = nb;
        end

        // R10: nibble sweeps, low then high
        pn = 4'h0;
        for (int v = 0; v < 16; v++) begin
            xfer({4'b0110, 4'(v)}, '0, 0, r0, rx);
            check("R10 R8 prior low", 64'(r0), 64'(pn));
            xfer(8'b1110_0000, '0, 0, r0, rx);
            check("R10 read low", 64'(r0), 64'(v));
            check("R10 low out", 64'(lo), 64'(v));
            pn = 4'(v);
        end
        pn = 4'h0;
        for (int v = 15; v >= 0; v--) begin
            xfer({4'b0111, 4'(v)}, '0, 0, r0, rx);
            check("R10 R8 prior high", 64'(r0), 64'(pn));
            xfer(8'b1111_0000, '0, 0, r0, rx);
            check("R10 read high", 64'(r0), 64'(v));
            pn = 4'(v);
        end
        check("R10 low kept", 64'(lo), 64'd15);

        // R11: switch sweep
        for (int v = 0; v < 16; v++) begin
            sw = 4'(v);
            xfer(8'b1101_0000, '0, 0, r0, rx);
            check("R11 switches", 64'(r0), 64'(v));
        end

        // R12: clear command
        xfer(8'b0100_0000, '0, 0, r0, rx);
        check("R12 R8 clear answers bank", 64'(r0), 64'({2'b00, pb}));
        for (int i = 0; i < 64; i++) slot_at(i, DEF, "R12 cleared");
        check("R12 bank kept", 64'(bank), 64'(pb));
        check("R12 nibbles kept", 64'({hi, lo}), 64'({4'd0, 4'd15}));
        check("R8 idle miso end", 64'(miso), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule